// File: doc/BRIEF.md
# Bus manager burst sequencer

This block sits on the manager side of an AHB bus. It takes one burst command at a time, made up of a start address, a transfer size, a length code, a wrap flag and a direction. It turns that command into address-phase signalling: a NONSEQ first beat, then SEQ beats whose address it advances or wraps itself, then IDLE. Write data for each beat is taken from a local source when the beat is issued. It goes onto the write data bus in the data phase that follows the accepted address phase. Read data is handed to a local sink as each read data phase completes.

The sequencer follows bus wait states. While HREADY is low the current address phase and the write data are frozen. If the local source has no write data, or the local sink has no room, when the next beat is due, the sequencer drives BUSY. During BUSY it already presents the address and control of that pending beat, and it resumes with SEQ once the local side is ready again.

Top module: `ahbm_burst_gen`

## Requirements
- R1: While rst_n is low, htrans is IDLE (2'b00), haddr, hsize, hburst and hwdata are zero, hwrite is low and rd_valid is low.
- R2: With no command pending, htrans stays IDLE. cmd_ready is high whenever htrans is IDLE, hready is high and the local side for cmd_write is ready (wr_avail for writes, rd_space for reads).
- R3: The first beat of every command is NONSEQ (2'b10) and carries cmd_addr, cmd_size and cmd_write. hburst encodes length and kind as single 0, wrap4 2, incr4 3, wrap8 4, incr8 5, wrap16 6, incr16 7.
- R4: Every later beat is SEQ (2'b11), and its hsize, hburst and hwrite equal those of the first beat.
- R5: In a non-wrapping burst each beat's address is the previous beat's address plus 2^hsize bytes.
- R6: In a wrapping burst the addresses stay inside the aligned block of beats×2^hsize bytes that holds the start address, advancing by 2^hsize and wrapping back to the block base.
- R7: When the next beat is due but wr_avail (for writes) or rd_space (for reads) is low, htrans is BUSY (2'b01) with haddr equal to that next beat's address, and the beat later follows as SEQ.
- R8: While hready is low, haddr, htrans, hsize, hburst, hwrite and a pending hwdata keep their values.
- R9: Each write beat consumes one wr_data word, pulsing wr_take, in beat order. That word appears on hwdata for the data phase that follows the beat's accepted address phase.
- R10: A read data phase that completes with hready high raises rd_valid in that cycle, and rd_data equals hrdata.
- R11: After the last beat's address phase is accepted, htrans returns to IDLE and done pulses high for exactly one cycle.
- R12: cmd_len selects 1, 4, 8 or 16 beats for codes 0, 1, 2 and 3, and exactly that many address phases are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Command is taken on this edge if cmd_valid is high |
| cmd_addr | input | AW | Start byte address |
| cmd_size | input | 3 | Transfer size, bytes = 2^cmd_size |
| cmd_len | input | 2 | Length code: 1, 4, 8 or 16 beats |
| cmd_wrap | input | 1 | 1 = wrapping burst, 0 = incrementing |
| cmd_write | input | 1 | 1 = write, 0 = read |
| wr_data | input | DW | Local write data word |
| wr_avail | input | 1 | Local write data word is present |
| wr_take | output | 1 | wr_data is consumed on this edge |
| rd_data | output | DW | Read data handed to the local sink |
| rd_valid | output | 1 | rd_data is valid this cycle |
| rd_space | input | 1 | Local sink can take one more read beat |
| done | output | 1 | One-cycle pulse after the final beat's address phase |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst kind and length |
| hwrite | output | 1 | Transfer direction |
| hwdata | output | DW | Write data bus |
| hrdata | input | DW | Read data bus |
| hready | input | 1 | Bus transfer ready / wait state control |

## Verification
Address-phase results (htrans, haddr, control) change on the edge that accepts the command or the previous beat, so they are due one cycle after the accepting edge. Write data appears one cycle after its beat's address is accepted and stays there until hready is seen high. Read data and rd_valid are combinational in that data-phase cycle. The bench samples everything half a cycle after the edge that produced it. Its bus monitor therefore logs each beat at the sample where hready and a beat type coincide, and logs each data word at the first later sample with hready high. All expected addresses, burst codes and data words are computed in the bench from the requirement text.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  // Length code to beat count (R12)
  function automatic logic [4:0] beats_of(input logic [1:0] len);
    case (len)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // Burst kind code on the bus (R3)
  function automatic logic [2:0] burst_code(input logic [1:0] len, input logic wrap);
    if (len == 2'd0) return 3'd0;
    return {len, ~wrap};
  endfunction

endpackage

// File: rtl/ahbm_addr_step.sv
module ahbm_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    size,
  input  logic [1:0]    len,
  input  logic          wrap,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step, span, mask, inc;

  always_comb begin
    step = AW'(1) << size;
    span = AW'(ahbm_pkg::beats_of(len)) << size;
    mask = span - AW'(1);
    inc  = cur + step;
    if (wrap && len != 2'd0) nxt = (cur & ~mask) | (inc & mask);
    else                     nxt = inc;
  end
endmodule

// File: rtl/ahbm_seq.sv
module ahbm_seq
  import ahbm_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [2:0]    cmd_size,
  input  logic [1:0]    cmd_len,
  input  logic          cmd_wrap,
  input  logic          cmd_write,
  input  logic          wr_avail,
  input  logic          rd_space,
  input  logic          hready,
  output logic          wr_take,
  output logic          accept,
  output logic          done,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic          hwrite
);
  localparam int LW = 4;

  trans_e        htrans_q;
  logic [AW-1:0] haddr_q, nxt_addr;
  logic [2:0]    hsize_q, hburst_q;
  logic          hwrite_q, wrap_q, done_q;
  logic [1:0]    len_q;
  logic [LW-1:0] left_q;

  // Named internal events
  logic beat, idle, start, last_acc, src_ok_cmd, src_ok_cur, cont, issue_seq;

  assign beat       = htrans_q[1];
  assign idle       = (htrans_q == TR_IDLE);
  assign src_ok_cmd = cmd_write ? wr_avail : rd_space;
  assign src_ok_cur = hwrite_q ? wr_avail : rd_space;
  assign cmd_ready  = idle && hready && src_ok_cmd;
  assign start      = cmd_valid && cmd_ready;
  assign accept     = hready && beat;
  assign last_acc   = accept && (left_q == '0);
  assign cont       = hready && ((beat && left_q != '0) || htrans_q == TR_BUSY);
  assign issue_seq  = cont && src_ok_cur;
  assign wr_take    = (start && cmd_write) || (issue_seq && hwrite_q);

  ahbm_addr_step #(.AW(AW)) u_step (
    .cur (haddr_q),
    .size(hsize_q),
    .len (len_q),
    .wrap(wrap_q),
    .nxt (nxt_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr_q  <= '0;
      htrans_q <= TR_IDLE;
      hsize_q  <= '0;
      hburst_q <= '0;
      hwrite_q <= 1'b0;
      wrap_q   <= 1'b0;
      len_q    <= '0;
      left_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_acc;
      if (start) begin
        haddr_q  <= cmd_addr;
        hsize_q  <= cmd_size;
        hwrite_q <= cmd_write;
        wrap_q   <= cmd_wrap;
        len_q    <= cmd_len;
        hburst_q <= burst_code(cmd_len, cmd_wrap);
        left_q   <= LW'(beats_of(cmd_len) - 5'd1);
        htrans_q <= TR_NSEQ;
      end else if (last_acc) begin
        htrans_q <= TR_IDLE;
      end else if (accept) begin
        haddr_q  <= nxt_addr;
        left_q   <= left_q - LW'(1);
        htrans_q <= src_ok_cur ? TR_SEQ : TR_BUSY;
      end else if (hready && htrans_q == TR_BUSY && src_ok_cur) begin
        htrans_q <= TR_SEQ;
      end
    end
  end

  assign haddr  = haddr_q;
  assign htrans = htrans_q;
  assign hsize  = hsize_q;
  assign hburst = hburst_q;
  assign hwrite = hwrite_q;
  assign done   = done_q;

  // R8: the address phase is frozen across a wait state
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && htrans_q[1]) |=> ($stable(haddr_q) && $stable(htrans_q) &&
      $stable(hsize_q) && $stable(hburst_q) && $stable(hwrite_q)));

  // R4: SEQ beats keep the control of the burst
  a_r4_seq_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_SEQ) |-> ($stable(hsize_q) && $stable(hburst_q) && $stable(hwrite_q)));

  // R5: incrementing bursts step by the transfer size
  a_r5_incr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_SEQ && hburst_q[0] && $past(hready) && $past(htrans_q[1]))
      |-> (haddr_q == $past(haddr_q) + (AW'(1) << hsize_q)));

  // R7: BUSY only inside a burst
  a_r7_busy_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_BUSY) |-> ($past(htrans_q) != TR_IDLE));

  // R3: a NONSEQ beat that was not stalled comes straight from IDLE
  a_r3_nseq_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == TR_NSEQ && $past(hready)) |-> ($past(htrans_q) == TR_IDLE));

  // R11: the done pulse coincides with the return to IDLE
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (htrans_q == TR_IDLE));
endmodule

// File: rtl/ahbm_dphase.sv
module ahbm_dphase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hready,
  input  logic          accept,
  input  logic          beat_write,
  input  logic          wr_take,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] hrdata,
  output logic [DW-1:0] hwdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] stage_q, hwdata_q;
  logic          dp_vld, dp_wr;
  logic          rd_done;

  assign rd_done = dp_vld && !dp_wr && hready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      hwdata_q <= '0;
      dp_vld   <= 1'b0;
      dp_wr    <= 1'b0;
    end else begin
      if (wr_take) stage_q <= wr_data;
      if (accept && beat_write) hwdata_q <= stage_q;
      if (accept) begin
        dp_vld <= 1'b1;
        dp_wr  <= beat_write;
      end else if (hready) begin
        dp_vld <= 1'b0;
      end
    end
  end

  assign hwdata   = hwdata_q;
  assign rd_data  = hrdata;
  assign rd_valid = rd_done;

  // R8: pending write data held through wait states
  a_r8_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_vld && dp_wr && !hready) |=> $stable(hwdata_q));

  // R10: read delivery only inside a read data phase
  a_r10_rd_phase: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (hready && $past(rd_done || accept || (dp_vld && !hready))));
endmodule

// File: rtl/ahbm_burst_gen.sv
module ahbm_burst_gen #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [2:0]    cmd_size,
  input  logic [1:0]    cmd_len,
  input  logic          cmd_wrap,
  input  logic          cmd_write,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_avail,
  output logic          wr_take,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_space,
  output logic          done,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic          hwrite,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready
);
  logic accept;

  ahbm_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_addr (cmd_addr),
    .cmd_size (cmd_size),
    .cmd_len  (cmd_len),
    .cmd_wrap (cmd_wrap),
    .cmd_write(cmd_write),
    .wr_avail (wr_avail),
    .rd_space (rd_space),
    .hready   (hready),
    .wr_take  (wr_take),
    .accept   (accept),
    .done     (done),
    .haddr    (haddr),
    .htrans   (htrans),
    .hsize    (hsize),
    .hburst   (hburst),
    .hwrite   (hwrite)
  );

  ahbm_dphase #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .hready    (hready),
    .accept    (accept),
    .beat_write(hwrite),
    .wr_take   (wr_take),
    .wr_data   (wr_data),
    .hrdata    (hrdata),
    .hwdata    (hwdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: tb/ahbm_burst_gen_bench.sv
module ahbm_burst_gen_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic [2:0]  cmd_size = '0;
  logic [1:0]  cmd_len = '0;
  logic        cmd_wrap = 1'b0;
  logic        cmd_write = 1'b0;
  logic [31:0] wr_data = 32'hC0DE_0000;
  logic        wr_avail = 1'b1;
  logic        wr_take;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        rd_space = 1'b1;
  logic        done;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst;
  logic        hwrite;
  logic [31:0] hwdata;
  logic [31:0] hrdata = '0;
  logic        hready = 1'b1;

  always #2.5 clk = ~clk;

  ahbm_burst_gen u_ahbm_burst_gen (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_len(cmd_len), .cmd_wrap(cmd_wrap),
    .cmd_write(cmd_write), .wr_data(wr_data), .wr_avail(wr_avail), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_space(rd_space), .done(done),
    .haddr(haddr), .htrans(htrans), .hsize(hsize), .hburst(hburst), .hwrite(hwrite),
    .hwdata(hwdata), .hrdata(hrdata), .hready(hready)
  );

  int n_chk = 0, n_bad = 0;
  bit stall_h = 0, stall_w = 0, stall_r = 0;

  // Monitor state: written only by the monitor process
  int cyc = 0, wr_idx = 0, n_beat = 0, n_wd = 0, n_rd = 0, rd_bad = 0;
  int busy_cnt = 0, busy_bad = 0, hold_bad = 0, ctrl_bad = 0, done_cnt = 0;
  bit take_seen = 0, pend = 0, pend_wr = 0, busy_pend = 0, prev_stall = 0, prev_dstall = 0;
  logic [31:0] pend_addr = '0, busy_addr = '0, p_addr = '0, p_wd = '0;
  logic [1:0]  p_tr = '0;
  logic [31:0] b_addr [0:63];
  logic [1:0]  b_tr   [0:63];
  logic [2:0]  b_burst[0:63];
  logic [31:0] wd_log [0:63];
  logic [2:0]  c_size, c_burst;
  logic        c_write;

  function automatic logic [31:0] rd_pat(input logic [31:0] a);
    return a ^ 32'h5EED_0000;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (take_seen) begin wr_idx++; take_seen = 0; end
    wr_data  = 32'hC0DE_0000 + 32'(wr_idx);
    hready   = !(stall_h && (cyc % 3 == 2));
    wr_avail = !(stall_w && (cyc % 5 == 3));
    rd_space = !(stall_r && (cyc % 4 == 1));
    #0.5;
    if (rst_n) begin
      if (prev_stall && (haddr !== p_addr || htrans !== p_tr)) hold_bad++;
      if (prev_dstall && hwdata !== p_wd) hold_bad++;
      prev_stall  = !hready && htrans[1];
      prev_dstall = pend && pend_wr && !hready;
      p_addr = haddr; p_tr = htrans; p_wd = hwdata;
      if (pend && hready) begin
        if (pend_wr) begin
          if (n_wd < 64) wd_log[n_wd] = hwdata;
          n_wd++;
        end else begin
          if (!rd_valid || rd_data !== rd_pat(pend_addr)) rd_bad++;
          n_rd++;
        end
        pend = 0;
      end
      if (htrans == 2'b01) begin busy_cnt++; busy_pend = 1; busy_addr = haddr; end
      if (hready && htrans[1]) begin
        if (busy_pend) begin
          if (haddr !== busy_addr) busy_bad++;
          busy_pend = 0;
        end
        if (htrans == 2'b10) begin c_size = hsize; c_burst = hburst; c_write = hwrite; end
        else if (hsize !== c_size || hburst !== c_burst || hwrite !== c_write) ctrl_bad++;
        if (n_beat < 64) begin
          b_addr[n_beat] = haddr; b_tr[n_beat] = htrans; b_burst[n_beat] = hburst;
        end
        n_beat++;
        pend = 1; pend_wr = hwrite; pend_addr = haddr;
        hrdata = rd_pat(haddr);
      end
      if (wr_take) take_seen = 1;
      if (done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // R1: outputs during reset
  task automatic t_reset();
    repeat (2) @(negedge clk);
    #1;
    check(htrans == 2'b00, "R1 htrans in reset", 32'(htrans), 0);
    check(haddr == 0 && hsize == 0 && hburst == 0 && hwrite == 0, "R1 addr/ctrl in reset",
          haddr, 0);
    check(hwdata == 0 && rd_valid == 0, "R1 data outputs in reset", hwdata, 0);
  endtask

  // R2: idle when nothing requested
  task automatic t_idle();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      check(htrans == 2'b00, "R2 idle without command", 32'(htrans), 0);
    end
    check(cmd_ready == 1'b1, "R2 cmd_ready while idle", 32'(cmd_ready), 1);
  endtask

  task automatic t_burst(input logic [31:0] a, input logic [2:0] sz, input logic [1:0] ln,
                         input logic wr, input logic wp, input bit sh, input bit sw, input bit sr,
                         input string tag);
    int nb, bytes, lb, guard, b0, w0, r0, bz0, bb0, hb0, d0, c0, idx0, exp_b;
    logic [31:0] base, ea;
    nb = (ln == 0) ? 1 : (ln == 1) ? 4 : (ln == 2) ? 8 : 16;
    bytes = 1 << sz;
    lb = nb * bytes;
    b0 = n_beat; w0 = n_wd; r0 = n_rd; bz0 = busy_cnt; bb0 = busy_bad; hb0 = hold_bad;
    d0 = done_cnt; c0 = ctrl_bad; idx0 = wr_idx;
    @(posedge clk); #1;
    stall_h = sh; stall_w = sw; stall_r = sr;
    cmd_addr = a; cmd_size = sz; cmd_len = ln; cmd_write = wr; cmd_wrap = wp; cmd_valid = 1'b1;
    guard = 0;
    while (htrans == 2'b00 && guard < 3000) begin @(posedge clk); #1; guard++; end
    cmd_valid = 1'b0;
    while ((n_wd - w0) + (n_rd - r0) < nb && guard < 3000) begin @(posedge clk); #1; guard++; end
    repeat (3) @(posedge clk);
    #1;
    stall_h = 0; stall_w = 0; stall_r = 0;
    check(guard < 3000, {tag, " R11 burst completes"}, guard, 0);
    check(n_beat - b0 == nb, {tag, " R12 accepted beat count"}, n_beat - b0, nb);
    exp_b = (ln == 0) ? 0 : (2 * ln + (wp ? 0 : 1));
    check(b_burst[b0] == 3'(exp_b), {tag, " R3 hburst code"}, 32'(b_burst[b0]), exp_b);
    check(c_size == sz && c_write == wr, {tag, " R3 first beat control"}, 32'(c_size), 32'(sz));
    check(ctrl_bad == c0, {tag, " R4 SEQ control unchanged"}, ctrl_bad - c0, 0);
    base = a - (a % lb);
    for (int k = 0; k < nb && b0 + k < 64; k++) begin
      if (wp && ln != 0) ea = base + ((a - base + 32'(k * bytes)) % lb);
      else               ea = a + 32'(k * bytes);
      check(b_addr[b0 + k] == ea, wp ? {tag, " R6 wrap address"} : {tag, " R5 incr address"},
            b_addr[b0 + k], ea);
      check(b_tr[b0 + k] == ((k == 0) ? 2'b10 : 2'b11), {tag, " R3 R4 beat type"},
            32'(b_tr[b0 + k]), (k == 0) ? 2 : 3);
    end
    if (wr) begin
      for (int k = 0; k < nb && w0 + k < 64; k++)
        check(wd_log[w0 + k] == 32'hC0DE_0000 + 32'(idx0 + k), {tag, " R9 write data order"},
              wd_log[w0 + k], 32'hC0DE_0000 + 32'(idx0 + k));
    end else begin
      check(n_rd - r0 == nb, {tag, " R10 read beats delivered"}, n_rd - r0, nb);
      check(rd_bad == 0, {tag, " R10 rd_valid and rd_data"}, rd_bad, 0);
    end
    check(done_cnt - d0 == 1, {tag, " R11 single done pulse"}, done_cnt - d0, 1);
    check(htrans == 2'b00, {tag, " R11 back to IDLE"}, 32'(htrans), 0);
    if (sh) check(hold_bad == hb0, {tag, " R8 stable in wait state"}, hold_bad - hb0, 0);
    if (sw || sr) begin
      check(busy_cnt > bz0, {tag, " R7 BUSY inserted"}, busy_cnt - bz0, 1);
      check(busy_bad == bb0, {tag, " R7 BUSY shows next address"}, busy_bad - bb0, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_idle();
    t_burst(32'h0000_0040, 3'd2, 2'd0, 1'b1, 1'b0, 0, 0, 0, "single write");
    t_burst(32'h0000_0100, 3'd2, 2'd1, 1'b1, 1'b0, 0, 0, 0, "incr4 write");
    t_burst(32'h0000_003C, 3'd1, 2'd2, 1'b0, 1'b1, 0, 0, 0, "wrap8 read");
    t_burst(32'h0000_0203, 3'd0, 2'd3, 1'b1, 1'b0, 1, 1, 0, "incr16 write stalled");
    t_burst(32'h0000_0018, 3'd2, 2'd1, 1'b1, 1'b1, 1, 0, 0, "wrap4 write waits");
    t_burst(32'h0000_0400, 3'd2, 2'd2, 1'b0, 1'b0, 1, 0, 1, "incr8 read busy");
    t_burst(32'h0000_0034, 3'd2, 2'd3, 1'b0, 1'b1, 0, 0, 1, "wrap16 read busy");
    finish_run();
  end
endmodule